// File: doc/BRIEF.md
# Threshold-Gated Multi-Channel Transmit Buffer

This block holds outgoing sample words for several independent channels between an application that streams 32-bit words in and a framer that pulls them out. Each channel has its own circular store, fill counter and drain state. A single threshold value is shared by all channels. It sets when a channel tells the application that it can take more data. It also sets how full a channel must get before the framer may begin taking words from it.

The write side is a ready/valid stream with a ready latency of one cycle. A word may be offered in the cycle after any cycle in which the channel's ready was high. A channel refuses to release anything until its fill level has reached the threshold. After that it hands out one word per read request until it runs dry. It then waits for the threshold again. The delay through a channel therefore follows the programmed threshold. Channels reach their threshold at different times, because each one is filled by its own stream.

Top module: `tgb_multi`

## Requirements
- R1: A channel's ready output is high exactly when its fill count is at or below its sampled threshold. The sampled threshold is the threshold input clamped to DEPTH-2 and registered one cycle earlier.
- R2: Words leave a channel in the order they were written, with their 32-bit value unchanged.
- R3: A write offered while the channel holds DEPTH words is dropped, and status bit 0 (overflow) is set. The bit stays set until reset.
- R4: While a channel is waiting, read requests remove nothing. Once the fill count is nonzero and at least the sampled threshold, status bit 2 (draining) is set on the next cycle.
- R5: While draining, each read request removes one word. When the channel becomes empty, status bit 2 clears, and the threshold must be reached again before draining resumes.
- R6: A read request on a channel that is not draining returns zero data and sets status bit 1 (underflow). The bit stays set until reset.
- R7: The read data for a request appears in the cycle after the request. In every cycle that follows no removal, the read data is zero.
- R8: Channels share the threshold input but never affect one another's fill, ready, data or status.
- R9: The threshold input is sampled only while a channel is waiting. A change during draining has no effect on that channel's ready output until draining ends.
- R10: Synchronous reset empties every channel, clears all status bits and read data, and leaves ready high.
- R11: A writer that offers words only in cycles following a ready-high cycle never causes an overflow, even at the largest threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr | input | CNT_W | Shared fill threshold |
| wr_valid | input | NUM_CH | Per-channel write strobe |
| wr_data | input | NUM_CH*DATA_W | Per-channel write words, channel 0 in the low bits |
| wr_ready | output | NUM_CH | Per-channel readiness, one-cycle latency |
| rd_req | input | NUM_CH | Per-channel read request from the framer |
| rd_data | output | NUM_CH*DATA_W | Per-channel word read out, valid the cycle after the request |
| status | output | NUM_CH*3 | Per channel: bit 0 overflow, bit 1 underflow, bit 2 draining |

## Verification
A wrong fill count shows up on ready within one cycle, because ready compares the count against the threshold every cycle. A pointer or storage fault shows up as a wrong word on the read data in the cycle after the first affected request. A drain state that is wrong appears in status bit 2 one cycle after the threshold crossing or the last removal. Its effect then appears as zero data with a raised underflow bit, or as words released too early. The bench sweeps every threshold value, including values above the clamp, and compares every output of both channels in every cycle against an arithmetic model.

// File: rtl/tgb_pkg.sv
package tgb_pkg;
   localparam int ST_OVF = 0;
   localparam int ST_UDF = 1;
   localparam int ST_DRN = 2;
   localparam int ST_W   = 3;

   typedef enum logic {
      ARM_WAIT = 1'b0,
      DRAINING = 1'b1
   } drain_st_t;
endpackage

// File: rtl/tgb_store.sv
module tgb_store #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PTR_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tgb_chan.sv
module tgb_chan
   import tgb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [CNT_W-1:0]  thr,
   input  logic              wr_valid,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_ready,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [ST_W-1:0]   status
);
   localparam logic [CNT_W-1:0] THR_MAX = CNT_W'(DEPTH - 2);
   localparam logic [CNT_W-1:0] FULL_V  = CNT_W'(DEPTH);

   logic [CNT_W-1:0]  fill_q, thr_q, thr_clip;
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   drain_st_t         st_q;
   logic              ovf_q, udf_q;
   logic [DATA_W-1:0] rdat_q, mem_rd;
   logic              full, push, pop;

   assign full     = (fill_q == FULL_V);
   assign push     = wr_valid && !full;
   assign pop      = rd_req && (st_q == DRAINING) && (fill_q != '0);
   assign thr_clip = (thr > THR_MAX) ? THR_MAX : thr;

   tgb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
      .clk   (clk),
      .we    (push),
      .waddr (wptr_q),
      .wdata (wr_data),
      .raddr (rptr_q),
      .rdata (mem_rd)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         fill_q <= '0;
         thr_q  <= '0;
         wptr_q <= '0;
         rptr_q <= '0;
         st_q   <= ARM_WAIT;
         ovf_q  <= 1'b0;
         udf_q  <= 1'b0;
         rdat_q <= '0;
      end else begin
         if (push) wptr_q <= wptr_q + PTR_W'(1);
         if (pop)  rptr_q <= rptr_q + PTR_W'(1);
         case ({push, pop})
            2'b10:   fill_q <= fill_q + CNT_W'(1);
            2'b01:   fill_q <= fill_q - CNT_W'(1);
            default: fill_q <= fill_q;
         endcase
         if (wr_valid && full) ovf_q <= 1'b1;
         if (rd_req && !pop)   udf_q <= 1'b1;
         rdat_q <= pop ? mem_rd : '0;
         if (st_q == ARM_WAIT) begin
            thr_q <= thr_clip;
            if (fill_q >= thr_q && fill_q != '0) st_q <= DRAINING;
         end else if (pop && !push && fill_q == CNT_W'(1)) begin
            st_q <= ARM_WAIT;
         end
      end
   end

   assign wr_ready        = (fill_q <= thr_q);
   assign rd_data         = rdat_q;
   assign status[ST_OVF]  = ovf_q;
   assign status[ST_UDF]  = udf_q;
   assign status[ST_DRN]  = (st_q == DRAINING);

   // R4: draining only begins from a fill that met the sampled threshold
   p_drain_entry_r4: assert property (@(posedge clk) disable iff (rst)
      $rose(status[ST_DRN]) |-> ($past(fill_q) >= $past(thr_q)) && ($past(fill_q) != '0));
   // R3: fill never exceeds the store size, and overflow stays latched
   p_fill_bound_r3: assert property (@(posedge clk) disable iff (rst)
      fill_q <= FULL_V);
   p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst)
      ovf_q |=> ovf_q);
   // R6: underflow stays latched, and a refused request yields zero data
   p_udf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
      udf_q |=> udf_q);
   p_udf_zero_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_req && st_q == ARM_WAIT) |=> (rd_data == '0));
   // R9: sampled threshold frozen while draining
   p_thr_frozen_r9: assert property (@(posedge clk) disable iff (rst)
      (st_q == DRAINING) |=> $stable(thr_q));
   // R5: an empty channel is never in the draining state
   p_empty_waits_r5: assert property (@(posedge clk) disable iff (rst)
      (fill_q == '0) |-> (st_q == ARM_WAIT));
endmodule

// File: rtl/tgb_multi.sv
module tgb_multi
   import tgb_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [CNT_W-1:0]         thr,
   input  logic [NUM_CH-1:0]        wr_valid,
   input  logic [NUM_CH*DATA_W-1:0] wr_data,
   output logic [NUM_CH-1:0]        wr_ready,
   input  logic [NUM_CH-1:0]        rd_req,
   output logic [NUM_CH*DATA_W-1:0] rd_data,
   output logic [NUM_CH*ST_W-1:0]   status
);
   if (NUM_CH < 1 || NUM_CH > 24) begin : g_bad_nch
      $error("tgb_multi: NUM_CH must lie in 1..24");
   end
   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("tgb_multi: DEPTH must be a power of two, at least 4");
   end
   if (DATA_W < 1) begin : g_bad_dw
      $error("tgb_multi: DATA_W must be positive");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      tgb_chan #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_chan (
         .clk      (clk),
         .rst      (rst),
         .thr      (thr),
         .wr_valid (wr_valid[c]),
         .wr_data  (wr_data[c*DATA_W +: DATA_W]),
         .wr_ready (wr_ready[c]),
         .rd_req   (rd_req[c]),
         .rd_data  (rd_data[c*DATA_W +: DATA_W]),
         .status   (status[c*ST_W +: ST_W])
      );
   end
endmodule

// File: tb/test_tgb_multi.sv
`timescale 1ns/1ps
module test_tgb_multi;
   localparam int NCH = 2;
   localparam int DW  = 32;
   localparam int DEP = 8;
   localparam int CW  = 4;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst;
   logic [CW-1:0]     thr;
   logic [NCH-1:0]    wv, rdy, rq;
   logic [NCH*DW-1:0] wd, rd;
   logic [NCH*3-1:0]  st;

   tgb_multi #(.NUM_CH(NCH), .DATA_W(DW), .DEPTH(DEP)) i_tgb_multi (
      .clk(clk), .rst(rst), .thr(thr), .wr_valid(wv), .wr_data(wd),
      .wr_ready(rdy), .rd_req(rq), .rd_data(rd), .status(st));

   int checks = 0;
   int errors = 0;

   int          m_fill [NCH];
   int          m_thr  [NCH];
   bit          m_drn  [NCH];
   bit          m_ovf  [NCH];
   bit          m_udf  [NCH];
   logic [31:0] m_rd   [NCH];
   logic [31:0] m_q    [NCH][$];
   logic [31:0] seq_no;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int clampt(int t);
      return (t > DEP - 2) ? DEP - 2 : t;
   endfunction

   task automatic cyc();
      int  n_fill [NCH];
      bit  n_drn  [NCH];
      int  n_thr  [NCH];
      for (int c = 0; c < NCH; c++) begin
         n_fill[c] = m_fill[c];
         n_drn[c]  = m_drn[c];
         n_thr[c]  = m_thr[c];
      end
      for (int c = 0; c < NCH; c++) begin
         bit push, pop;
         if (rst) begin
            n_fill[c] = 0; n_drn[c] = 0; n_thr[c] = 0;
            m_ovf[c] = 0; m_udf[c] = 0; m_rd[c] = '0; m_q[c].delete();
         end else begin
            push = wv[c] && (m_fill[c] < DEP);
            pop  = rq[c] && m_drn[c] && (m_fill[c] > 0);
            if (wv[c] && m_fill[c] == DEP) m_ovf[c] = 1;
            if (rq[c] && !pop) m_udf[c] = 1;
            m_rd[c] = '0;
            if (pop) m_rd[c] = m_q[c].pop_front();
            if (push) m_q[c].push_back(wd[c*DW +: DW]);
            n_fill[c] = m_fill[c] + (push ? 1 : 0) - (pop ? 1 : 0);
            if (!m_drn[c]) begin
               n_thr[c] = clampt(int'(thr));
               if (m_fill[c] >= m_thr[c] && m_fill[c] != 0) n_drn[c] = 1;
            end else if (pop && !push && m_fill[c] == 1) begin
               n_drn[c] = 0;
            end
         end
      end
      @(posedge clk);
      #2;
      for (int c = 0; c < NCH; c++) begin
         m_fill[c] = n_fill[c]; m_drn[c] = n_drn[c]; m_thr[c] = n_thr[c];
         chk("R1", 32'(rdy[c]), 32'(m_fill[c] <= m_thr[c]));
         chk("R3", 32'(st[c*3+0]), 32'(m_ovf[c]));
         chk("R6", 32'(st[c*3+1]), 32'(m_udf[c]));
         chk("R4", 32'(st[c*3+2]), 32'(m_drn[c]));
         if (m_rd[c] != 0) chk("R2", rd[c*DW +: DW], m_rd[c]);
         else              chk("R7", rd[c*DW +: DW], m_rd[c]);
      end
   endtask

   task automatic idle_in();
      wv = '0; rq = '0; wd = '0;
   endtask

   task automatic do_reset();
      rst = 1'b1; idle_in();
      cyc(); cyc();
      rst = 1'b0;
   endtask

   initial begin
      #(20.0 * 200000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      bit prev_rdy0;
      seq_no = 32'h1000;
      thr = '0;
      do_reset();
      // R10: state after reset
      chk("R10", 32'(rdy), 32'h3);
      chk("R10", 32'(st), 32'h0);
      chk("R10", rd[31:0], 32'h0);

      // Threshold sweep on channel 0; channel 1 gets a different pattern (R8)
      for (int t = 0; t < 8; t++) begin
         int k;
         do_reset();
         thr = CW'(t);
         cyc();
         prev_rdy0 = rdy[0];
         k = 0;
         while (!st[2] && k < 20) begin
            wv[0] = prev_rdy0;               // ready latency one (R11)
            wd[31:0] = seq_no; seq_no++;
            wv[1] = k[0];
            wd[63:32] = 32'hA000_0000 + 32'(k);
            rq[1] = (k % 3 == 2);
            prev_rdy0 = rdy[0];
            cyc();
            k++;
         end
         chk("R4", 32'(st[2]), 32'h1);
         // change threshold mid-drain; channel must ignore it (R9)
         thr = CW'(7 - t);
         wv = '0; rq = 2'b01;
         cyc();
         chk("R9", 32'(rdy[0]), 32'(m_fill[0] <= clampt(t)));
         k = 0;
         while (st[2] && k < 20) begin
            cyc();
            k++;
         end
         rq = '0;
         cyc();
         chk("R5", 32'(st[2]), 32'h0);
         chk("R5", 32'(m_fill[0]), 32'h0);
         chk("R11", 32'(st[0]), 32'h0);
      end

      // Overflow on channel 0 only, writes ignoring ready (R3, R8)
      do_reset();
      thr = CW'(7);
      for (int i = 0; i < 11; i++) begin
         wv = 2'b01; wd[31:0] = 32'hB000_0000 + 32'(i);
         cyc();
      end
      idle_in();
      cyc();
      chk("R3", 32'(st[0]), 32'h1);
      chk("R8", 32'(st[5:3]), 32'h0);
      chk("R8", 32'(rdy[1]), 32'h1);
      // drain all eight in order (R2)
      rq = 2'b01;
      for (int i = 0; i < 9; i++) cyc();
      rq = '0;
      cyc();
      chk("R5", 32'(st[2]), 32'h0);
      chk("R6", 32'(st[1]), 32'h1);
      chk("R3", 32'(st[0]), 32'h1);

      // Underflow on waiting channel 1, data must be zero (R6, R7)
      do_reset();
      thr = CW'(3);
      wv = 2'b10; wd[63:32] = 32'hC0DE_0001;
      cyc();
      wv = '0; rq = 2'b10;
      cyc();
      chk("R6", rd[63:32], 32'h0);
      chk("R6", 32'(st[4]), 32'h1);
      chk("R8", 32'(st[1]), 32'h0);
      rq = '0;
      cyc();

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule